// File: doc/BRIEF.md
# Grouped Completion Interrupt Unit

The unit turns per-slot completion flags into interrupt requests. Three transfer classes (isochronous, periodic interrupt-transfer and asynchronous) each present a vector of done flags, one per descriptor slot. For each class, software programs two group masks. The all-of mask raises the class request once every slot it selects has finished. The any-of mask raises it as soon as one selected slot has finished. A fourth source follows the frame tick.

A shared latency value, counted in whole frame ticks of 125 microseconds, can hold a class request back after its group condition first holds. Each source latches into a sticky status bit. Writing a one to that bit clears it. A per-source enable bit decides whether the status bit reaches its interrupt pin. Software reaches all registers through a simple write-only port. Status is seen only through the interrupt pins.

Top module: `gci_top`

## Requirements
- R1: After a synchronous reset, all four interrupt outputs are low. Both masks of every class are zero, all enables are zero, and the latency is zero.
- R2: A class's all-of condition holds when its all-of mask (address 2c, with class c = 0 iso, 1 interrupt-transfer, 2 async) is non-zero and every done bit it selects is set. An all-of mask of zero never satisfies.
- R3: A class's any-of condition holds when at least one done bit selected by its any-of mask (address 2c+1) is set.
- R4: Done bits selected by neither mask of a class have no effect on that class.
- R5: With latency 0, a class status bit sets on the first clock edge at which its condition holds. Its interrupt output goes high in the cycle after that edge.
- R6: With latency N > 0 (address 7, bits [LAT_W-1:0]), a class is armed at the first edge where its condition holds. Its status sets on the edge of the Nth frame tick that arrives after arming, and not before.
- R7: A status bit stays set after the condition that set it goes away.
- R8: A write to address 8 clears each status bit whose data bit is one. Bit 0 is iso, bit 1 interrupt-transfer, bit 2 async and bit 3 frame. Zero bits leave their status unchanged. A cleared class is re-evaluated from the next edge, so a condition that still holds sets the status again.
- R9: The frame status bit sets at every clock edge where the frame tick input is high. A tick in the same cycle takes priority over a clear.
- R10: Each interrupt output equals its status bit ANDed with its enable bit. The enable bits are at address 6 and use the same bit order as R8. Disabling an output does not discard its status.
- R11: The three classes are independent. Done flags, masks and clears of one class do not change another class's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_iso | input | SLOTS | Isochronous slot done flags |
| done_intr | input | SLOTS | Interrupt-transfer slot done flags |
| done_async | input | SLOTS | Asynchronous slot done flags |
| sof_tick | input | 1 | One-cycle frame tick pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| irq_iso | output | 1 | Isochronous interrupt request |
| irq_intr | output | 1 | Interrupt-transfer interrupt request |
| irq_async | output | 1 | Asynchronous interrupt request |
| irq_sof | output | 1 | Frame interrupt request |

## Verification
The bound checker watches several rules on every cycle. It checks that status bits hold until cleared, that a clear empties them on the next edge, and that the frame status follows each tick. It checks that a zero latency turns a true condition into status at once, and that with a non-zero latency no status appears in a cycle without a tick. The bench's scenarios show the rest: which mask and done patterns satisfy the all-of and any-of groups, the exact tick count before a delayed request appears, re-raising after a clear, enable gating that keeps status, and isolation between classes.

// File: rtl/gci_pkg.sv
package gci_pkg;
    parameter int unsigned SLOTS  = 32;
    parameter int unsigned LAT_W  = 4;
    parameter int unsigned NCLS   = 3;
    localparam int unsigned NSRC  = NCLS + 1;
    localparam int unsigned SOF_I = NCLS;

    typedef logic [SLOTS-1:0] slot_vec_t;

    typedef struct packed {
        slot_vec_t all_m;
        slot_vec_t any_m;
    } grp_mask_t;

    typedef enum logic [3:0] {
        A_ALL_ISO  = 4'd0,
        A_ANY_ISO  = 4'd1,
        A_ALL_INTR = 4'd2,
        A_ANY_INTR = 4'd3,
        A_ALL_ASY  = 4'd4,
        A_ANY_ASY  = 4'd5,
        A_ENABLE   = 4'd6,
        A_LATENCY  = 4'd7,
        A_CLEAR    = 4'd8
    } reg_addr_e;

    function automatic logic group_met(input slot_vec_t done, input grp_mask_t m);
        logic all_ok;
        logic any_ok;
        all_ok = (m.all_m != '0) && ((done & m.all_m) == m.all_m);
        any_ok = |(done & m.any_m);
        return all_ok || any_ok;
    endfunction
endpackage

// File: rtl/gci_regs.sv
module gci_regs
    import gci_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [31:0]       wr_data,
    output grp_mask_t         masks [NCLS],
    output logic [NSRC-1:0]   enable,
    output logic [LAT_W-1:0]  latency,
    output logic [NSRC-1:0]   clr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCLS; c++) masks[c] <= '0;
            enable  <= '0;
            latency <= '0;
        end else if (wr_en) begin
            for (int c = 0; c < NCLS; c++) begin
                if (wr_addr == 4'(2*c))   masks[c].all_m <= wr_data[SLOTS-1:0];
                if (wr_addr == 4'(2*c+1)) masks[c].any_m <= wr_data[SLOTS-1:0];
            end
            if (wr_addr == A_ENABLE)  enable  <= wr_data[NSRC-1:0];
            if (wr_addr == A_LATENCY) latency <= wr_data[LAT_W-1:0];
        end
    end

    assign clr = (wr_en && wr_addr == A_CLEAR) ? wr_data[NSRC-1:0] : '0;
endmodule

// File: rtl/gci_class_unit.sv
module gci_class_unit
    import gci_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  slot_vec_t        done,
    input  grp_mask_t        mask,
    input  logic [LAT_W-1:0] latency,
    input  logic             sof_tick,
    input  logic             clr,
    output logic             cond,
    output logic             status
);
    logic             armed;
    logic [LAT_W-1:0] ticks;
    logic [LAT_W:0]   ticks_nxt;

    assign cond      = group_met(done, mask);
    assign ticks_nxt = {1'b0, ticks} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            status <= 1'b0;
            armed  <= 1'b0;
            ticks  <= '0;
        end else if (!status) begin
            if (latency == '0) begin
                if (cond) status <= 1'b1;
                armed <= 1'b0;
                ticks <= '0;
            end else if (!armed) begin
                if (cond) armed <= 1'b1;
                ticks <= '0;
            end else if (sof_tick) begin
                if (ticks_nxt >= {1'b0, latency}) begin
                    status <= 1'b1;
                    armed  <= 1'b0;
                    ticks  <= '0;
                end else begin
                    ticks <= ticks_nxt[LAT_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/gci_sof_unit.sv
module gci_sof_unit (
    input  logic clk,
    input  logic rst,
    input  logic sof_tick,
    input  logic clr,
    output logic status
);
    always_ff @(posedge clk) begin
        if (rst)           status <= 1'b0;
        else if (sof_tick) status <= 1'b1;
        else if (clr)      status <= 1'b0;
    end
endmodule

// File: rtl/gci_top.sv
module gci_top
    import gci_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SLOTS-1:0] done_iso,
    input  logic [SLOTS-1:0] done_intr,
    input  logic [SLOTS-1:0] done_async,
    input  logic             sof_tick,
    input  logic             wr_en,
    input  logic [3:0]       wr_addr,
    input  logic [31:0]      wr_data,
    output logic             irq_iso,
    output logic             irq_intr,
    output logic             irq_async,
    output logic             irq_sof
);
    grp_mask_t        masks [NCLS];
    logic [NSRC-1:0]  enable;
    logic [LAT_W-1:0] latency;
    logic [NSRC-1:0]  clr;
    logic [NSRC-1:0]  st;
    logic [NCLS-1:0]  cond;
    slot_vec_t        done_a [NCLS];
    logic [NSRC-1:0]  irq_v;

    assign done_a[0] = done_iso;
    assign done_a[1] = done_intr;
    assign done_a[2] = done_async;

    gci_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .masks   (masks),
        .enable  (enable),
        .latency (latency),
        .clr     (clr)
    );

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        gci_class_unit u_cls (
            .clk      (clk),
            .rst      (rst),
            .done     (done_a[c]),
            .mask     (masks[c]),
            .latency  (latency),
            .sof_tick (sof_tick),
            .clr      (clr[c]),
            .cond     (cond[c]),
            .status   (st[c])
        );
    end

    gci_sof_unit u_sof (
        .clk      (clk),
        .rst      (rst),
        .sof_tick (sof_tick),
        .clr      (clr[SOF_I]),
        .status   (st[SOF_I])
    );

    assign irq_v     = st & enable;
    assign irq_iso   = irq_v[0];
    assign irq_intr  = irq_v[1];
    assign irq_async = irq_v[2];
    assign irq_sof   = irq_v[SOF_I];
endmodule

// File: rtl/gci_checks.sv
module gci_checks
    import gci_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sof_tick,
    input logic [NSRC-1:0]  st,
    input logic [NSRC-1:0]  clr,
    input logic [NCLS-1:0]  cond,
    input logic [LAT_W-1:0] latency,
    input logic [NSRC-1:0]  irq
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> irq == '0);

    p_sof_sets_r9: assert property (@(posedge clk) disable iff (rst)
        sof_tick |=> st[SOF_I]);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
            st[i] && !clr[i] |=> st[i]);
    end

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        p_lat0_set_r5: assert property (@(posedge clk) disable iff (rst)
            latency == '0 && cond[c] && !clr[c] |=> st[c]);

        p_no_early_r6: assert property (@(posedge clk) disable iff (rst)
            latency != '0 && !sof_tick && !st[c] |=> !st[c]);

        p_clear_r8: assert property (@(posedge clk) disable iff (rst)
            clr[c] |=> !st[c]);
    end
endmodule

bind gci_top gci_checks u_chk (
    .clk      (clk),
    .rst      (rst),
    .sof_tick (sof_tick),
    .st       (st),
    .clr      (clr),
    .cond     (cond),
    .latency  (latency),
    .irq      (irq_v)
);

// File: tb/test_gci_top.sv
`timescale 1ns/1ps
module test_gci_top;
    import gci_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic [SLOTS-1:0] done_iso, done_intr, done_async;
    logic             sof_tick;
    logic             wr_en;
    logic [3:0]       wr_addr;
    logic [31:0]      wr_data;
    logic             irq_iso, irq_intr, irq_async, irq_sof;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    gci_top i_gci_top (
        .clk(clk), .rst(rst),
        .done_iso(done_iso), .done_intr(done_intr), .done_async(done_async),
        .sof_tick(sof_tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_iso(irq_iso), .irq_intr(irq_intr), .irq_async(irq_async), .irq_sof(irq_sof)
    );

    typedef struct packed {
        logic [31:0] all_m;
        logic [31:0] any_m;
        logic [31:0] done;
        logic        exp;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{32'h0000_000F, 32'h0,          32'h0000_000F, 1'b1},
        '{32'h0000_000F, 32'h0,          32'h0000_0007, 1'b0},
        '{32'h0,         32'h0,          32'hFFFF_FFFF, 1'b0},
        '{32'h0,         32'h0000_0100,  32'h0000_0100, 1'b1},
        '{32'h0,         32'h0000_0100,  32'h0000_0200, 1'b0},
        '{32'h0000_00F0, 32'h0000_0001,  32'h0000_00F0, 1'b1},
        '{32'h0000_00F0, 32'h0000_0001,  32'h0000_00E1, 1'b1},
        '{32'h8000_0001, 32'h0,          32'h8000_0001, 1'b1},
        '{32'h8000_0001, 32'h0,          32'h8000_0000, 1'b0}
    };

    task automatic check(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        sof_tick = 1'b1;
        @(negedge clk);
        sof_tick = 1'b0;
    endtask

    initial begin
        #(4ns * 200000);
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; done_iso = '0; done_intr = '0; done_async = '0;
        sof_tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state, outputs low
        check("R1 iso", irq_iso, 1'b0);
        check("R1 sof", irq_sof, 1'b0);
        // R1: masks cleared, so nothing fires even with all done and enables on
        wr(A_ENABLE, 32'h7);
        done_iso = '1; done_intr = '1; done_async = '1;
        repeat (2) @(negedge clk);
        check("R1 iso mask zero", irq_iso, 1'b0);
        check("R1 intr mask zero", irq_intr, 1'b0);
        check("R1 async mask zero", irq_async, 1'b0);
        done_iso = '0; done_intr = '0; done_async = '0;

        // R2/R3/R4 table on the iso class, latency 0
        wr(A_ENABLE, 32'h1);
        foreach (VEC[k]) begin
            done_iso = '0;
            wr(A_ALL_ISO, VEC[k].all_m);
            wr(A_ANY_ISO, VEC[k].any_m);
            wr(A_CLEAR, 32'h1);
            done_iso = VEC[k].done;
            repeat (2) @(negedge clk);
            check($sformatf("R2/R3/R4 vector %0d", k), irq_iso, VEC[k].exp);
        end

        // R5: exact timing with latency 0
        done_iso = '0;
        wr(A_ALL_ISO, 32'h0);
        wr(A_ANY_ISO, 32'h1);
        wr(A_CLEAR, 32'h1);
        @(negedge clk);
        done_iso = 32'h1;
        #1 check("R5 before edge", irq_iso, 1'b0);
        @(negedge clk);
        check("R5 after one edge", irq_iso, 1'b1);

        // R7: sticky after condition drops
        done_iso = '0;
        repeat (3) @(negedge clk);
        check("R7 sticky", irq_iso, 1'b1);

        // R8: zero bits leave status, one bit clears
        wr(A_CLEAR, 32'hE);
        check("R8 zero bit no effect", irq_iso, 1'b1);
        wr(A_CLEAR, 32'h1);
        check("R8 cleared", irq_iso, 1'b0);
        // R8: re-evaluation when condition still holds
        done_iso = 32'h1;
        @(negedge clk);
        check("R8 set again", irq_iso, 1'b1);
        wr(A_CLEAR, 32'h1);
        check("R8 low one cycle", irq_iso, 1'b0);
        @(negedge clk);
        check("R8 re-raised", irq_iso, 1'b1);

        // R10: disable hides, status kept
        wr(A_ENABLE, 32'h0);
        done_iso = '0;
        check("R10 gated off", irq_iso, 1'b0);
        wr(A_ENABLE, 32'h7);
        check("R10 status kept", irq_iso, 1'b1);

        // R6: latency of 3 frame ticks on the interrupt-transfer class
        wr(A_CLEAR, 32'hF);
        wr(A_LATENCY, 32'd3);
        wr(A_ANY_INTR, 32'h20);
        done_intr = 32'h20;
        repeat (3) @(negedge clk);
        check("R6 no tick yet", irq_intr, 1'b0);
        tick();
        tick();
        check("R6 after two ticks", irq_intr, 1'b0);
        done_intr = '0;
        tick();
        check("R6 after third tick", irq_intr, 1'b1);
        // R11: other classes untouched
        check("R11 iso untouched", irq_iso, 1'b0);
        check("R11 async untouched", irq_async, 1'b0);
        // R11: async condition does not disturb intr status clear
        wr(A_LATENCY, 32'd0);
        wr(A_ANY_ASY, 32'h2);
        done_async = 32'h2;
        @(negedge clk);
        check("R11 async own", irq_async, 1'b1);
        wr(A_CLEAR, 32'h4);
        check("R11 intr kept", irq_intr, 1'b1);
        done_async = '0;

        // R9: frame status on every tick
        wr(A_ENABLE, 32'h8);
        wr(A_CLEAR, 32'h8);
        check("R9 cleared", irq_sof, 1'b0);
        tick();
        check("R9 tick sets", irq_sof, 1'b1);
        wr(A_CLEAR, 32'h8);
        check("R9 cleared again", irq_sof, 1'b0);
        // R9: tick wins over simultaneous clear
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_CLEAR; wr_data = 32'h8; sof_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sof_tick = 1'b0;
        check("R9 tick beats clear", irq_sof, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule